// File: doc/BRIEF.md
# Asymmetric Decode Steering with Micro-op Queue

This block is the decode stage of a front end whose instructions expand into a variable number of micro-operations. Each cycle the fetch side offers up to three already-delimited instructions, oldest in slot 0. Each instruction carries its micro-op count and a payload. The block steers them onto three decoders. Decoder 0 is wide and emits up to four micro-ops. Decoders 1 and 2 are narrow and emit one micro-op each. Steering is strictly in program order. An instruction that needs more than one micro-op can only use decoder 0, so when it sits behind an older instruction, decode stops in front of it for that cycle.

Instructions that expand to more than four micro-ops take a sequenced path through decoder 0. That path produces four micro-ops per accepted cycle until the count is used up, and the other two decoders stay idle meanwhile. Every micro-op is the instruction payload joined with its index. The micro-ops are written into a six-entry queue, and dispatch pulls up to three of them, oldest first, every cycle. A cycle's decode is taken only when all its micro-ops fit. Otherwise nothing moves, and the upstream side keeps presenting the same instructions until `in_taken` reports how many were consumed. A flush empties the queue and abandons any sequence in progress.

Top module: `uop_decode_steer`

## Requirements
- R1: After reset the queue is empty: `out_num` is 0, no sequenced instruction is in progress, and `in_taken` is 0 while `in_num` is 0.
- R2: The slot-0 instruction, with a count from 1 to 4, produces that many micro-ops on decoder 0. Slots 1 and 2 are decoded only when their count is exactly 1, and then produce one micro-op each. The count of slot i sits in `in_cnt[4i+3:4i]` and its payload in `in_pay[16i+15:16i]`.
- R3: The decoded slots always form a prefix of the offered ones. A slot-1 or slot-2 instruction whose count is not 1 is not decoded, and neither is any younger one. Slots at or above `in_num` are ignored. `in_taken` equals the length of the prefix.
- R4: A micro-op is `{payload[15:0], index[3:0]}`, with the index counting from 0. The micro-ops of one cycle enter the queue in this order: decoder 0 in index order, then slot 1, then slot 2.
- R5: A slot-0 instruction with a count above 4 emits four micro-ops with consecutive indices in each accepted cycle, and only the remainder in its final cycle. `in_taken` stays 0 until the cycle that emits the final micro-op, where it is 1. Slots 1 and 2 are never decoded alongside it.
- R6: A cycle's decode is accepted only if the occupancy at the start of the cycle plus the micro-ops produced is at most 6; that cycle's drain is not credited. When decode is refused, nothing is written, `in_taken` is 0, and a sequence keeps its position.
- R7: `out_num` equals min(3, occupancy). Lane k of `out_uop` (bits [20k+19:20k]) holds the k-th oldest entry, and the entries shown leave the queue at the clock edge.
- R8: In a cycle with `flush` high, `in_taken` and `out_num` are 0. After that edge the queue is empty, and a sequenced instruction starts again from index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the queue and abandon the sequence |
| in_num | input | 2 | Number of valid instructions offered, filled from slot 0 |
| in_cnt | input | 12 | Micro-op count per slot, 4 bits each |
| in_pay | input | 48 | Payload per slot, 16 bits each |
| in_taken | output | 2 | Instructions consumed this cycle |
| out_num | output | 2 | Micro-ops leaving toward dispatch this cycle |
| out_uop | output | 60 | Three micro-op lanes, 20 bits each, oldest in lane 0 |

## Verification
The bench uses the default parameters: three decoders, a four-wide complex decoder, a six-entry queue, three drain lanes and 4-bit counts. With these values, a single group of 4+1+1 fills the queue in one cycle, so the refuse-and-hold rule shows up on the very next cycle. Sequenced counts of 8 and 10 cover both an exact four-way split and a remainder, with refusals for space falling between their chunks. A flush in the middle of a sequence shows that the next sequenced instruction starts again at index 0.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

   // Wraps an index that is below twice the limit back into [0, lim).
   function automatic int unsigned dsq_wrap(input int unsigned v, input int unsigned lim);
      return (v >= lim) ? v - lim : v;
   endfunction

endpackage

// File: rtl/dsq_steer.sv
module dsq_steer #(
   parameter int unsigned PAY_W    = 16,
   parameter int unsigned CNT_W    = 4,
   parameter int unsigned DEC_N    = 3,
   parameter int unsigned CPX_UOPS = 4,
   parameter int unsigned Q_DEPTH  = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush,
   input  logic [$clog2(DEC_N+1)-1:0]  in_num,
   input  logic [DEC_N*CNT_W-1:0]      in_cnt,
   input  logic [DEC_N*PAY_W-1:0]      in_pay,
   input  logic [CNT_W-1:0]            seq_base,
   input  logic [$clog2(Q_DEPTH+1)-1:0] q_free,
   output logic                        wr_en,
   output logic [$clog2(CPX_UOPS+DEC_N)-1:0] wr_n,
   output logic [(CPX_UOPS+DEC_N-1)*(PAY_W+CNT_W)-1:0] wr_uop,
   output logic [$clog2(DEC_N+1)-1:0]  take_n,
   output logic                        seq_adv,
   output logic [CNT_W-1:0]            seq_nxt
);

   localparam int unsigned UOP_W  = PAY_W + CNT_W;
   localparam int unsigned WR_MAX = CPX_UOPS + DEC_N - 1;
   localparam int unsigned NUM_W  = $clog2(DEC_N + 1);
   localparam int unsigned WRN_W  = $clog2(WR_MAX + 1);

   logic [CNT_W-1:0] cnt [DEC_N];
   logic [PAY_W-1:0] pay [DEC_N];
   logic [UOP_W-1:0] slot_uop [WR_MAX];
   logic [DEC_N-1:0] d_ok;
   logic             is_uc, uc_last, go;
   logic [CNT_W-1:0] uc_rem, uc_chunk, n0;
   logic [WRN_W-1:0] n_tot;
   logic [NUM_W-1:0] n_take;

   genvar gs;
   generate
      for (gs = 0; gs < DEC_N; gs++) begin : g_unpack
         assign cnt[gs] = in_cnt[gs*CNT_W +: CNT_W];
         assign pay[gs] = in_pay[gs*PAY_W +: PAY_W];
      end
   endgenerate

   // Sequenced path: slot-0 instruction wider than the complex decoder.
   always_comb begin
      is_uc    = (in_num != '0) && (cnt[0] > CNT_W'(CPX_UOPS));
      uc_rem   = cnt[0] - seq_base;
      uc_last  = uc_rem <= CNT_W'(CPX_UOPS);
      uc_chunk = uc_last ? uc_rem : CNT_W'(CPX_UOPS);
   end

   // In-order prefix: decoder 0 takes anything up to its width,
   // each narrow decoder continues the chain only with a single-uop op.
   assign d_ok[0] = (in_num != '0) && !is_uc;
   generate
      for (gs = 1; gs < DEC_N; gs++) begin : g_simple
         assign d_ok[gs] = d_ok[gs-1] && (in_num > NUM_W'(gs)) && (cnt[gs] == CNT_W'(1));
      end
   endgenerate

   assign n0 = d_ok[0] ? cnt[0] : '0;

   always_comb begin
      if (is_uc) begin
         n_tot  = WRN_W'(uc_chunk);
         n_take = uc_last ? NUM_W'(1) : '0;
      end else begin
         n_tot  = WRN_W'(n0);
         n_take = '0;
         for (int i = 0; i < int'(DEC_N); i++)
            if (d_ok[i]) n_take = n_take + 1'b1;
         for (int i = 1; i < int'(DEC_N); i++)
            if (d_ok[i]) n_tot = n_tot + 1'b1;
      end
   end

   // Micro-op placement: decoder 0 first, then narrow decoders in slot order.
   always_comb begin
      for (int k = 0; k < int'(WR_MAX); k++) begin
         slot_uop[k] = '0;
         if (is_uc) begin
            if (k < int'(CPX_UOPS)) slot_uop[k] = {pay[0], seq_base + CNT_W'(k)};
         end else begin
            if (CNT_W'(k) < n0) slot_uop[k] = {pay[0], CNT_W'(k)};
            for (int i = 1; i < int'(DEC_N); i++)
               if (d_ok[i] && (k == int'(n0) + i - 1)) slot_uop[k] = {pay[i], CNT_W'(0)};
         end
      end
   end

   generate
      for (gs = 0; gs < WR_MAX; gs++) begin : g_pack
         assign wr_uop[gs*UOP_W +: UOP_W] = slot_uop[gs];
      end
   endgenerate

   assign go      = !flush && (int'(n_tot) <= int'(q_free));
   assign wr_en   = go;
   assign wr_n    = n_tot;
   assign take_n  = go ? n_take : '0;
   assign seq_adv = go && is_uc;
   assign seq_nxt = uc_last ? '0 : seq_base + CNT_W'(CPX_UOPS);

   a_r3_take_bound: assert property (@(posedge clk) disable iff (!rst_n)
      take_n <= in_num);

   a_r5_ucode_alone: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_base != '0) |-> (take_n <= NUM_W'(1)) && (int'(wr_n) <= int'(CPX_UOPS)));

endmodule

// File: rtl/dsq_useq.sv
module dsq_useq #(
   parameter int unsigned CNT_W    = 4,
   parameter int unsigned CPX_UOPS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             adv,
   input  logic [CNT_W-1:0] nxt,
   output logic [CNT_W-1:0] base
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     base <= '0;
      else if (flush) base <= '0;
      else if (adv)   base <= nxt;
   end

   a_r8_flush_abort: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (base == '0));

   a_r5_chunk_step: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && (nxt != '0)) |=> (base == $past(base) + CNT_W'(CPX_UOPS)));

endmodule

// File: rtl/dsq_uopq.sv
module dsq_uopq
   import dsq_pkg::*;
#(
   parameter int unsigned UOP_W   = 20,
   parameter int unsigned Q_DEPTH = 6,
   parameter int unsigned WR_MAX  = 6,
   parameter int unsigned DRAIN_N = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic                          wr_en,
   input  logic [$clog2(WR_MAX+1)-1:0]   wr_n,
   input  logic [WR_MAX*UOP_W-1:0]       wr_uop,
   output logic [$clog2(Q_DEPTH+1)-1:0]  q_free,
   output logic [$clog2(DRAIN_N+1)-1:0]  out_num,
   output logic [DRAIN_N*UOP_W-1:0]      out_uop
);

   localparam int unsigned PTR_W  = $clog2(Q_DEPTH);
   localparam int unsigned QCNT_W = $clog2(Q_DEPTH + 1);
   localparam int unsigned ON_W   = $clog2(DRAIN_N + 1);

   logic [UOP_W-1:0]  mem [Q_DEPTH];
   logic [PTR_W-1:0]  head, tail;
   logic [QCNT_W-1:0] count;
   logic [ON_W-1:0]   rd_n;

   assign rd_n   = flush ? '0 : ((count >= QCNT_W'(DRAIN_N)) ? ON_W'(DRAIN_N) : ON_W'(count));
   assign q_free = QCNT_W'(Q_DEPTH) - count;
   assign tail   = PTR_W'(dsq_wrap(32'(head) + 32'(count), Q_DEPTH));

   always_ff @(posedge clk) begin
      if (wr_en)
         for (int k = 0; k < int'(WR_MAX); k++)
            if (k < int'(wr_n))
               mem[PTR_W'(dsq_wrap(32'(tail) + 32'(k), Q_DEPTH))] <= wr_uop[k*UOP_W +: UOP_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head  <= '0;
         count <= '0;
      end else if (flush) begin
         head  <= '0;
         count <= '0;
      end else begin
         head  <= PTR_W'(dsq_wrap(32'(head) + 32'(rd_n), Q_DEPTH));
         count <= count - QCNT_W'(rd_n) + (wr_en ? QCNT_W'(wr_n) : '0);
      end
   end

   genvar gk;
   generate
      for (gk = 0; gk < DRAIN_N; gk++) begin : g_lane
         assign out_uop[gk*UOP_W +: UOP_W] = mem[PTR_W'(dsq_wrap(32'(head) + 32'(gk), Q_DEPTH))];
      end
   endgenerate

   assign out_num = rd_n;

   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (32'(count) + 32'(wr_n) <= 32'(Q_DEPTH)));

   a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0));

   a_r7_drain_leaves: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !wr_en) |=> (count == $past(count) - QCNT_W'($past(out_num))));

endmodule

// File: rtl/uop_decode_steer.sv
module uop_decode_steer #(
   parameter  int unsigned PAY_W    = 16,
   parameter  int unsigned CNT_W    = 4,
   parameter  int unsigned DEC_N    = 3,
   parameter  int unsigned CPX_UOPS = 4,
   parameter  int unsigned Q_DEPTH  = 6,
   parameter  int unsigned DRAIN_N  = 3,
   localparam int unsigned UOP_W    = PAY_W + CNT_W,
   localparam int unsigned WR_MAX   = CPX_UOPS + DEC_N - 1,
   localparam int unsigned NUM_W    = $clog2(DEC_N + 1),
   localparam int unsigned ON_W     = $clog2(DRAIN_N + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic [NUM_W-1:0]         in_num,
   input  logic [DEC_N*CNT_W-1:0]   in_cnt,
   input  logic [DEC_N*PAY_W-1:0]   in_pay,
   output logic [NUM_W-1:0]         in_taken,
   output logic [ON_W-1:0]          out_num,
   output logic [DRAIN_N*UOP_W-1:0] out_uop
);

   localparam int unsigned QCNT_W = $clog2(Q_DEPTH + 1);
   localparam int unsigned WRN_W  = $clog2(WR_MAX + 1);

   generate
      if (DEC_N < 1) begin : g_chk_dec
         $error("DEC_N must be at least 1");
      end
      if (CPX_UOPS < 2 || CPX_UOPS >= (1 << CNT_W)) begin : g_chk_cpx
         $error("CPX_UOPS must lie in [2, 2**CNT_W)");
      end
      if (Q_DEPTH < WR_MAX || Q_DEPTH < 2) begin : g_chk_depth
         $error("Q_DEPTH must hold one full decode cycle");
      end
      if (DRAIN_N < 1 || DRAIN_N > Q_DEPTH) begin : g_chk_drain
         $error("DRAIN_N must lie in [1, Q_DEPTH]");
      end
   endgenerate

   logic [CNT_W-1:0]        seq_base, seq_nxt;
   logic                    seq_adv, wr_en;
   logic [WRN_W-1:0]        wr_n;
   logic [WR_MAX*UOP_W-1:0] wr_uop;
   logic [QCNT_W-1:0]       q_free;

   dsq_steer #(
      .PAY_W(PAY_W), .CNT_W(CNT_W), .DEC_N(DEC_N),
      .CPX_UOPS(CPX_UOPS), .Q_DEPTH(Q_DEPTH)
   ) u_steer (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .in_num(in_num), .in_cnt(in_cnt), .in_pay(in_pay),
      .seq_base(seq_base), .q_free(q_free),
      .wr_en(wr_en), .wr_n(wr_n), .wr_uop(wr_uop),
      .take_n(in_taken), .seq_adv(seq_adv), .seq_nxt(seq_nxt)
   );

   dsq_useq #(.CNT_W(CNT_W), .CPX_UOPS(CPX_UOPS)) u_useq (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .adv(seq_adv), .nxt(seq_nxt), .base(seq_base)
   );

   dsq_uopq #(
      .UOP_W(UOP_W), .Q_DEPTH(Q_DEPTH), .WR_MAX(WR_MAX), .DRAIN_N(DRAIN_N)
   ) u_queue (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .wr_en(wr_en), .wr_n(wr_n), .wr_uop(wr_uop),
      .q_free(q_free), .out_num(out_num), .out_uop(out_uop)
   );

endmodule

// File: tb/uop_decode_steer_bench.sv
`timescale 1ns/1ps
module uop_decode_steer_bench;

   localparam int PAY_W = 16;
   localparam int CNT_W = 4;
   localparam int DR    = 3;
   localparam int UOP_W = PAY_W + CNT_W;

   // {num[23:20], c0[19:16], c1[15:12], c2[11:8], take[7:4], uops[3:0]}
   localparam logic [23:0] VEC [11] = '{
      24'h3_111_33,   // R2 three simple
      24'h3_411_36,   // R2 full 4+1+1
      24'h3_121_11,   // R3 complex in slot 1 stops
      24'h3_113_22,   // R3 complex in slot 2 stops
      24'h2_310_24,   // R2 in_num limits to two
      24'h1_200_12,   // R2 lone two-uop op
      24'h0_111_00,   // R3 nothing offered
      24'h3_222_12,   // R3 complex chain
      24'h3_151_11,   // R3 sequenced op in slot 1 stops
      24'h2_111_22,   // R3 slot 2 ignored beyond in_num
      24'h3_421_14    // R3 wide slot 0 then complex
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic [1:0]  in_num = '0;
   logic [11:0] in_cnt = '0;
   logic [47:0] in_pay = '0;
   logic [1:0]  in_taken;
   logic [1:0]  out_num;
   logic [59:0] out_uop;

   always #2 clk = ~clk;

   uop_decode_steer u_uop_decode_steer (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .in_num(in_num), .in_cnt(in_cnt), .in_pay(in_pay),
      .in_taken(in_taken), .out_num(out_num), .out_uop(out_uop)
   );

   int checks = 0;
   int errors = 0;
   logic [UOP_W-1:0] exp_mem [512];
   int exp_wr = 0;
   int exp_rd = 0;
   int last_taken, last_num, last_rem, drained, n;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   task automatic set_in(input int num, input int c0, input int c1, input int c2, input logic [15:0] p);
      in_num = 2'(num);
      in_cnt = {4'(c2), 4'(c1), 4'(c0)};
      in_pay = {p + 16'd2, p + 16'd1, p};
   endtask

   task automatic push_instr(input logic [15:0] p, input int c);
      for (int j = 0; j < c; j++) begin
         exp_mem[exp_wr % 512] = {p, 4'(j)};
         exp_wr++;
      end
   endtask

   // Samples at the falling edge, compares drained lanes, returns after the rising edge.
   task automatic step();
      @(negedge clk);
      last_taken = int'(in_taken);
      last_num   = int'(out_num);
      last_rem   = exp_wr - exp_rd;
      for (int k = 0; k < DR; k++) begin
         logic [UOP_W-1:0] got;
         if (k < last_num) begin
            got = out_uop[k*UOP_W +: UOP_W];
            drained++;
            if (exp_rd == exp_wr) chk(1'b0, "R7 unexpected uop", 32'(got), 32'h0);
            else begin
               chk(got == exp_mem[exp_rd % 512], "R4/R7 uop value and order",
                   32'(got), 32'(exp_mem[exp_rd % 512]));
               exp_rd++;
            end
         end
      end
      @(posedge clk);
      #1;
   endtask

   task automatic drain();
      in_num = '0;
      for (int g = 0; g < 12; g++) begin
         if (exp_wr == exp_rd) break;
         step();
         chk(last_num == ((last_rem > DR) ? DR : last_rem), "R7 drain width",
             32'(last_num), 32'((last_rem > DR) ? DR : last_rem));
      end
      chk(exp_wr == exp_rd, "R7 all expected uops drained", 32'(exp_rd), 32'(exp_wr));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      step();
      chk(last_num == 0, "R1 queue empty after reset", 32'(last_num), 32'd0);
      chk(last_taken == 0, "R1 nothing taken with no input", 32'(last_taken), 32'd0);

      // Vector walk: R2/R3/R4 from an empty queue
      for (int r = 0; r < 11; r++) begin
         logic [23:0]  v;
         logic [15:0]  pb;
         v  = VEC[r];
         pb = 16'hA000 + 16'(r * 16);
         set_in(int'(v[23:20]), int'(v[19:16]), int'(v[15:12]), int'(v[11:8]), pb);
         step();
         chk(last_taken == int'(v[7:4]), "R2/R3 instructions taken", 32'(last_taken), 32'(v[7:4]));
         for (int s = 0; s < int'(v[7:4]); s++)
            push_instr(pb + 16'(s), (s == 0) ? int'(v[19:16]) : (s == 1) ? int'(v[15:12]) : int'(v[11:8]));
         drained = 0;
         drain();
         chk(drained == int'(v[3:0]), "R2 uops produced", 32'(drained), 32'(v[3:0]));
      end

      // R6 full queue refuses and holds
      set_in(3, 4, 1, 1, 16'hB000);
      step();
      chk(last_taken == 3, "R6 group fits empty queue", 32'(last_taken), 32'd3);
      push_instr(16'hB000, 4); push_instr(16'hB001, 1); push_instr(16'hB002, 1);
      step();
      chk(last_taken == 0, "R6 refused on full queue", 32'(last_taken), 32'd0);
      chk(last_num == 3, "R7 three leave from full queue", 32'(last_num), 32'd3);
      step();
      chk(last_taken == 0, "R6 drain in same cycle not credited", 32'(last_taken), 32'd0);
      step();
      chk(last_taken == 3, "R6 accepted once space exists", 32'(last_taken), 32'd3);
      push_instr(16'hB000, 4); push_instr(16'hB001, 1); push_instr(16'hB002, 1);
      drain();

      // R5 sequenced count 10: chunks 4,4,2 with one space refusal
      set_in(3, 10, 1, 1, 16'hC000);
      push_instr(16'hC000, 10);
      n = 0;
      do begin step(); n++; end while (last_taken == 0 && n < 20);
      chk(last_taken == 1, "R5 only the sequenced op is taken", 32'(last_taken), 32'd1);
      chk(n == 4, "R5/R6 cycles for count 10", 32'(n), 32'd4);
      drain();

      // R5 sequenced count 8: exact chunks
      set_in(1, 8, 0, 0, 16'hD000);
      push_instr(16'hD000, 8);
      n = 0;
      do begin step(); n++; end while (last_taken == 0 && n < 20);
      chk(n == 3, "R5 cycles for count 8", 32'(n), 32'd3);
      drain();

      // R8 flush in the middle of a sequence
      set_in(1, 8, 0, 0, 16'hE000);
      step();
      chk(last_taken == 0, "R5 sequence still in progress", 32'(last_taken), 32'd0);
      flush = 1'b1;
      in_num = 2'd3;
      step();
      chk(last_taken == 0, "R8 nothing taken during flush", 32'(last_taken), 32'd0);
      chk(last_num == 0, "R8 nothing leaves during flush", 32'(last_num), 32'd0);
      flush = 1'b0;
      in_num = '0;
      step();
      chk(last_num == 0, "R8 queue empty after flush", 32'(last_num), 32'd0);
      set_in(1, 5, 0, 0, 16'hF000);
      push_instr(16'hF000, 5);
      n = 0;
      do begin step(); n++; end while (last_taken == 0 && n < 20);
      chk(n == 2, "R8 sequence restarts at index 0", 32'(n), 32'd2);
      drain();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule